// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block works out the next instruction address for a core whose program counter is 16 bits wide and counts in instruction words. Each issued control operation goes through the unit. It can be one of six compare-and-branch conditions, a branch on a single bit being set or clear, an unconditional relative branch, an absolute jump, or a jump that also returns a link address for the destination register. Fetch and decode happen elsewhere. The unit receives the current PC, the first source register, the raw second-operand candidates (an 8-bit immediate, a 16-bit immediate and a register), a selector that picks the immediate, a signed branch offset and an operation code.

The results are registered. They appear one clock after an issue strobe. Between issues the address and the link value hold, and the link write strobe stays low. The reset input is asynchronous when it asserts. Inside the block its release is synchronised to the clock.

Top module: `branch_target_unit`

## Requirements
- R1: While reset is asserted, and until the first issue after it, `next_pc`, `link_pc` and `link_we` are all zero.
- R2: Codes 0 to 5 are compare branches: 0 greater, 1 greater-or-equal, 2 less, 3 less-or-equal, 4 equal, 5 not-equal. Each one compares the branch operand against `src1` (operand on the left) as unsigned `DATA_W`-bit values. The branch operand is `imm8` zero-extended when `imm_sel` is 1, and `src2` otherwise.
- R3: A taken branch gives `cur_pc` plus `br_off` sign-extended, modulo 2^16. A branch that is not taken gives `cur_pc + 1`, modulo 2^16.
- R4: Code 6 always branches to `cur_pc` plus the sign-extended offset.
- R5: Code 7 branches when the bit of `src1` indexed by the low 5 bits of the branch operand is 1. Code 8 branches when that bit is 0.
- R6: Code 9 jumps to `imm16` when `imm_sel` is 1, and to `src2[15:0]` otherwise. The upper bits of `src2` have no effect.
- R7: Code 10 jumps in the same way as code 9. It also presents `cur_pc + 1` on `link_pc` and pulses `link_we` for exactly one cycle.
- R8: In a cycle where `issue` is 0, all other inputs are ignored. `next_pc` and `link_pc` keep their values and `link_we` is 0.
- R9: Codes 11 to 15 fall through to `cur_pc + 1` and do not raise `link_we`.
- R10: Results for an issue sampled at one rising clock edge are visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| issue | input | 1 | Operation valid this cycle |
| opcode | input | 4 | Operation code (see R2 to R9) |
| imm_sel | input | 1 | 1 selects the immediate operand |
| cur_pc | input | 16 | Address of the current instruction |
| src1 | input | 32 | First source register |
| src2 | input | 32 | Second source register |
| imm8 | input | 8 | Branch immediate |
| imm16 | input | 16 | Jump immediate |
| br_off | input | 10 | Signed branch offset in words |
| next_pc | output | 16 | Next instruction address |
| link_pc | output | 16 | Return address for jump-and-link |
| link_we | output | 1 | Link write strobe |

## Verification
The checker looks at every clock for the following. The link strobe fires only after a jump-and-link issue and carries the previous PC plus one. Address and link hold when nothing was issued. Absolute jumps and branch-always land where their operands point. Only the bench scenarios can show that each compare condition uses the correct operand order and unsigned ordering, that the immediate is zero-extended, that the bit index is masked, and how the address wraps at both ends of the 16-bit range. The bench compares every cycle against a behavioural model, over directed corner cases and a long run of random operations.

// File: rtl/bjt_pkg.sv
package bjt_pkg;
  localparam int OPC_W  = 4;
  localparam int BIDX_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_BGT   = 4'd0,
    OP_BGE   = 4'd1,
    OP_BLT   = 4'd2,
    OP_BLE   = 4'd3,
    OP_BEQ   = 4'd4,
    OP_BNE   = 4'd5,
    OP_BRA   = 4'd6,
    OP_BBSET = 4'd7,
    OP_BBCLR = 4'd8,
    OP_JMP   = 4'd9,
    OP_JAL   = 4'd10
  } ctl_op_e;

  typedef enum logic [1:0] {
    SRC_SEQ,
    SRC_REL,
    SRC_ABS
  } tgt_src_e;
endpackage

// File: rtl/bjt_operand.sv
module bjt_operand #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16,
  parameter int IMMB_W = 8
) (
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] src2,
  input  logic [IMMB_W-1:0] imm8,
  input  logic [PC_W-1:0]   imm16,
  output logic [DATA_W-1:0] br_opnd,
  output logic [PC_W-1:0]   jmp_opnd
);
  localparam int ZPAD_W = DATA_W - IMMB_W;

  // branch operand: zero-extended short immediate or register
  assign br_opnd  = imm_sel ? {{ZPAD_W{1'b0}}, imm8} : src2;
  // jump operand: full-width immediate or low bits of the register
  assign jmp_opnd = imm_sel ? imm16 : src2[PC_W-1:0];
endmodule

// File: rtl/bjt_cond.sv
module bjt_cond
  import bjt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] br_opnd,
  output tgt_src_e          tsel
);
  logic             bit_hit;
  logic             take;
  logic [BIDX_W-1:0] bidx;

  assign bidx    = br_opnd[BIDX_W-1:0];
  assign bit_hit = src1[bidx];

  always_comb begin
    take = 1'b0;
    tsel = SRC_SEQ;
    unique case (opcode)
      OP_BGT:   take = br_opnd >  src1;
      OP_BGE:   take = br_opnd >= src1;
      OP_BLT:   take = br_opnd <  src1;
      OP_BLE:   take = br_opnd <= src1;
      OP_BEQ:   take = br_opnd == src1;
      OP_BNE:   take = br_opnd != src1;
      OP_BRA:   take = 1'b1;
      OP_BBSET: take = bit_hit;
      OP_BBCLR: take = !bit_hit;
      default:  take = 1'b0;
    endcase
    if (opcode == OP_JMP || opcode == OP_JAL) tsel = SRC_ABS;
    else if (take)                            tsel = SRC_REL;
  end
endmodule

// File: rtl/bjt_target.sv
module bjt_target
  import bjt_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFFS_W = 10
) (
  input  tgt_src_e          tsel,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [OFFS_W-1:0] br_off,
  input  logic [PC_W-1:0]   jmp_opnd,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc
);
  logic [PC_W-1:0] off_ext;

  generate
    if (OFFS_W < PC_W) begin : g_sext
      assign off_ext = {{(PC_W-OFFS_W){br_off[OFFS_W-1]}}, br_off};
    end else begin : g_trunc
      assign off_ext = br_off[PC_W-1:0];
    end
  endgenerate

  assign seq_pc = cur_pc + {{(PC_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (tsel)
      SRC_REL: tgt_pc = cur_pc + off_ext;
      SRC_ABS: tgt_pc = jmp_opnd;
      default: tgt_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import bjt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16,
  parameter int IMMB_W = 8,
  parameter int OFFS_W = 10,
  parameter int RSYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              imm_sel,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [IMMB_W-1:0] imm8,
  input  logic [PC_W-1:0]   imm16,
  input  logic [OFFS_W-1:0] br_off,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   link_pc,
  output logic              link_we
);
  // reset: asynchronous assert, synchronous release
  logic [RSYNC-1:0] rst_pipe;
  logic             rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RSYNC-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RSYNC-1];

  logic [DATA_W-1:0] br_opnd;
  logic [PC_W-1:0]   jmp_opnd;
  tgt_src_e          tsel;
  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   tgt_pc;

  bjt_operand #(.DATA_W(DATA_W), .PC_W(PC_W), .IMMB_W(IMMB_W)) u_opnd (
    .imm_sel (imm_sel),
    .src2    (src2),
    .imm8    (imm8),
    .imm16   (imm16),
    .br_opnd (br_opnd),
    .jmp_opnd(jmp_opnd)
  );

  bjt_cond #(.DATA_W(DATA_W)) u_cond (
    .opcode (opcode),
    .src1   (src1),
    .br_opnd(br_opnd),
    .tsel   (tsel)
  );

  bjt_target #(.PC_W(PC_W), .OFFS_W(OFFS_W)) u_tgt (
    .tsel    (tsel),
    .cur_pc  (cur_pc),
    .br_off  (br_off),
    .jmp_opnd(jmp_opnd),
    .seq_pc  (seq_pc),
    .tgt_pc  (tgt_pc)
  );

  // next-state
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] link_d;
  logic            we_d;
  logic            is_jal;
  logic            pc_en;
  logic            link_en;

  assign is_jal  = (opcode == OP_JAL);
  assign pc_en   = issue;
  assign link_en = issue && is_jal;

  always_comb begin
    pc_d   = tgt_pc;
    link_d = seq_pc;
    we_d   = link_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_pc <= '0;
      link_pc <= '0;
      link_we <= 1'b0;
    end else begin
      if (pc_en)   next_pc <= pc_d;
      if (link_en) link_pc <= link_d;
      link_we <= we_d;
    end
  end
endmodule

// File: rtl/bjt_checker.sv
module bjt_checker
  import bjt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16,
  parameter int OFFS_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [OPC_W-1:0]  opcode,
  input logic              imm_sel,
  input logic [PC_W-1:0]   cur_pc,
  input logic [DATA_W-1:0] src2,
  input logic [PC_W-1:0]   imm16,
  input logic [OFFS_W-1:0] br_off,
  input logic [PC_W-1:0]   next_pc,
  input logic [PC_W-1:0]   link_pc,
  input logic              link_we
);
  logic [PC_W-1:0] rel_tgt;
  assign rel_tgt = cur_pc + PC_W'($signed(br_off));

  // link strobe only follows a jump-and-link issue
  assert_link_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> $past(issue && opcode == OP_JAL));

  // link value is the previous PC plus one
  assert_link_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_pc == $past(cur_pc) + 16'd1);

  // idle cycle leaves results unchanged
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(next_pc) && $stable(link_pc) && !link_we);

  // immediate absolute jump
  assert_jump_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == OP_JMP && imm_sel) |=> next_pc == $past(imm16));

  // register absolute jump
  assert_jump_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == OP_JMP && !imm_sel) |=> next_pc == $past(src2[PC_W-1:0]));

  // branch-always lands on PC plus offset
  assert_bra_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && opcode == OP_BRA) |=> next_pc == $past(rel_tgt));
endmodule

bind branch_target_unit bjt_checker #(
  .DATA_W(DATA_W), .PC_W(PC_W), .OFFS_W(OFFS_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .issue  (issue),
  .opcode (opcode),
  .imm_sel(imm_sel),
  .cur_pc (cur_pc),
  .src2   (src2),
  .imm16  (imm16),
  .br_off (br_off),
  .next_pc(next_pc),
  .link_pc(link_pc),
  .link_we(link_we)
);

// File: tb/sim_branch_target_unit.sv
module sim_branch_target_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = '0;
  logic        imm_sel = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [31:0] src1 = '0;
  logic [31:0] src2 = '0;
  logic [7:0]  imm8 = '0;
  logic [15:0] imm16 = '0;
  logic [9:0]  br_off = '0;
  logic [15:0] next_pc;
  logic [15:0] link_pc;
  logic        link_we;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int exp_pc = 0;
  int exp_lp = 0;
  int exp_we = 0;

  always #2 clk = ~clk;

  branch_target_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .imm_sel(imm_sel),
    .cur_pc(cur_pc), .src1(src1), .src2(src2), .imm8(imm8), .imm16(imm16),
    .br_off(br_off), .next_pc(next_pc), .link_pc(link_pc), .link_we(link_we)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int op, bit iss);
    if (!iss) return "R8";
    if (op <= 5) return "R2";
    if (op == 6) return "R4";
    if (op == 7 || op == 8) return "R5";
    if (op == 9) return "R6";
    if (op == 10) return "R7";
    return "R9";
  endfunction

  // behavioural reference: update expected state for one clock
  task automatic model();
    longint unsigned a, b;
    int off, rel, seq, tgt;
    bit take;
    if (!issue) begin
      exp_we = 0;
      return;
    end
    a = src1;
    b = imm_sel ? longint'(imm8) : longint'(src2);
    off = br_off;
    if (br_off[9]) off = off - 1024;
    seq = (cur_pc + 1) % 65536;
    rel = (cur_pc + off + 65536) % 65536;
    take = 0;
    case (opcode)
      0: take = b > a;
      1: take = b >= a;
      2: take = b < a;
      3: take = b <= a;
      4: take = b == a;
      5: take = b != a;
      6: take = 1;
      7: take = ((a >> (b % 32)) & 1) == 1;
      8: take = ((a >> (b % 32)) & 1) == 0;
      default: take = 0;
    endcase
    tgt = take ? rel : seq;
    if (opcode == 9 || opcode == 10) tgt = imm_sel ? int'(imm16) : int'(src2 & 32'hFFFF);
    exp_pc = tgt;
    exp_we = (opcode == 10) ? 1 : 0;
    if (opcode == 10) exp_lp = seq;
  endtask

  task automatic step(bit iss, int op, bit sel, int pc, logic [31:0] s1,
                      logic [31:0] s2, int i8, int i16, int off);
    string r;
    @(negedge clk);
    issue = iss; opcode = op[3:0]; imm_sel = sel; cur_pc = pc[15:0];
    src1 = s1; src2 = s2; imm8 = i8[7:0]; imm16 = i16[15:0]; br_off = off[9:0];
    r = req_of(op, iss);
    model();
    @(posedge clk);
    #1;
    // R10: result visible right after the sampling edge
    check(r, "next_pc", next_pc, exp_pc);
    check(r, "link_pc", link_pc, exp_lp);
    check(r, "link_we", link_we, exp_we);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "next_pc in reset", next_pc, 0);
    check("R1", "link_pc in reset", link_pc, 0);
    check("R1", "link_we in reset", link_we, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0, 0);   // R1 holds through release

    // R2 compare branches, operand order and unsigned
    step(1, 0, 1, 16'h0100, 32'd4, 0, 5, 0, 10);             // 5>4 taken
    step(1, 0, 1, 16'h0100, 32'd5, 0, 5, 0, 10);             // 5>5 not taken
    step(1, 1, 1, 16'h0200, 32'd5, 0, 5, 0, 10);             // GE equal
    step(1, 2, 0, 16'h0300, 32'd9, 32'd3, 0, 0, 20);         // 3<9
    step(1, 3, 0, 16'h0300, 32'd2, 32'd3, 0, 0, 20);         // 3<=2 no
    step(1, 4, 1, 16'h0400, 32'h000000FF, 0, 8'hFF, 0, 7);   // eq, zero-ext
    step(1, 5, 1, 16'h0400, 32'hFFFFFFFF, 0, 8'hFF, 0, 7);   // ne
    step(1, 0, 0, 16'h0500, 32'd1, 32'h80000000, 0, 0, 3);   // unsigned gt
    step(1, 0, 1, 16'h0500, 32'h0000007F, 0, 8'hFF, 0, 3);   // imm 255 > 127
    // R3 wrap both ends
    step(1, 6, 0, 16'h0002, 0, 0, 0, 0, -4);                 // 0xFFFE
    step(1, 4, 1, 16'hFFFF, 32'd1, 0, 0, 0, 5);              // not taken -> 0
    step(1, 6, 0, 16'hFFFE, 0, 0, 0, 0, 511);                // R4 positive wrap
    step(1, 6, 0, 16'h1000, 0, 0, 0, 0, -512);               // R4 most negative
    // R5 bit tests with index masking
    step(1, 7, 1, 16'h2000, 32'h80000000, 0, 8'hFF, 0, 9);   // bit 31 set
    step(1, 7, 1, 16'h2000, 32'h80000000, 0, 8'h3E, 0, 9);   // bit 30 clear
    step(1, 8, 0, 16'h2000, 32'h00000001, 32'h20, 0, 0, 9);  // idx 0 set -> no
    step(1, 8, 0, 16'h2000, 32'h00000001, 32'h21, 0, 0, 9);  // idx 1 clear
    // R6 jumps
    step(1, 9, 1, 16'h3000, 0, 32'hDEAD0000, 0, 16'hBEEF, 0);
    step(1, 9, 0, 16'h3000, 0, 32'hDEAD1234, 0, 16'hBEEF, 0);
    // R7 jump and link, then R8 idle with noisy inputs
    step(1, 10, 1, 16'hFFFF, 0, 0, 0, 16'h0040, 0);
    step(0, 10, 0, 16'h7777, 32'h5, 32'h6, 1, 2, 3);
    step(1, 10, 0, 16'h1234, 0, 32'h00005678, 0, 0, 0);
    // R9 unassigned codes
    for (int k = 11; k < 16; k++) step(1, k, 1, 16'h4000 + k, 32'hF, 32'hF, 8'hF, 16'h1111, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 2, $urandom % 65536,
           ($urandom % 4 == 0) ? ($urandom % 256) : $urandom,
           ($urandom % 4 == 0) ? ($urandom % 256) : $urandom,
           $urandom % 256, $urandom % 65536, $urandom % 1024);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule